// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the serial clock of an I2C master from the system clock. It alternates a low phase, in which it pulls the open-drain SCL wire down, with a high phase, in which it lets the wire go. A programmed clock-control count sets the length of both phases. Three timing shapes are offered: an even 1:1 split for standard mode, and two fast-mode splits, 2:1 and 16:9, that give the low side more time.

After each release the generator waits a programmed rise-time count. It also waits until it senses the line actually high. Only then does it time the high phase. A slave that holds SCL low therefore stretches the low phase. One-cycle marker pulses at the end of each low phase and each high phase tell a neighbouring byte shifter when to move data.

Configuration is taken only while the generator is disabled. Disabling it releases the line and clears all timing state.

Top module: `scl_timing_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `scl_oe`, `low_end` and `high_end` are all 0.
- R2: With `cfg_fast`=0 (standard mode), `scl_oe` is 1 (line pulled low) for C cycles. After the rise wait of R7 the line stays released for C more cycles. C is the clock-control count.
- R3: In standard mode a clock-control count below 4 is treated as 4.
- R4: With `cfg_fast`=1 and `cfg_duty16`=0, the low phase lasts 2C cycles and the high phase lasts C cycles after the rise wait.
- R5: With `cfg_fast`=1 and `cfg_duty16`=1, the low phase lasts 16C cycles and the high phase lasts 9C cycles after the rise wait.
- R6: In either fast setting a clock-control count of 0 is treated as 1.
- R7: After release, high-phase timing starts only once both of these hold: max(rise count,1) cycles have passed since release, and `scl_in` is high. While `scl_in` is held low the line stays released and no `high_end` occurs.
- R8: `low_end` is a one-cycle pulse in the first cycle in which `scl_oe` is 0 after a low phase. `high_end` is a one-cycle pulse in the first cycle in which `scl_oe` is 1 again after a high phase.
- R9: A `cfg_we` write while `enable` is 1 is discarded. It does not take effect later either.
- R10: One cycle after `enable` goes to 0, `scl_oe` is 0. After re-enabling, a full low phase begins in the next cycle.
- R11: While the stored MHz value is 0 the generator does not start, and `scl_oe` stays 0 even with `enable` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run the generator; configuration is locked while high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_fast | input | 1 | 0 = standard mode, 1 = fast mode |
| cfg_duty16 | input | 1 | In fast mode: 0 = 2:1, 1 = 16:9 |
| cfg_ccr | input | CCR_W | Clock-control count |
| cfg_rise | input | RISE_W | Rise-time count in input clocks |
| cfg_mhz | input | MHZ_W | Input clock rate in whole MHz |
| scl_in | input | 1 | Sensed SCL level |
| scl_oe | output | 1 | 1 = pull SCL low, 0 = release |
| low_end | output | 1 | Pulse when a low phase ends |
| high_end | output | 1 | Pulse when a high phase ends |

## Verification
A wrong phase length or a bad clamp shows up as a wrong run length of `scl_oe` within the first full SCL period after enabling. That is at most a few hundred cycles for small counts. A phase register stuck in the wrong state shows in the same period as a missing or misplaced `low_end`/`high_end` pulse. A lock that failed to hold would change the next measured period, as would a stretch that was not honoured. A disable that leaves state behind shows one cycle after `enable` falls, as `scl_oe` still asserted.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_RISE = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;
endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs #(
  parameter int CCR_W  = 12,
  parameter int RISE_W = 6,
  parameter int MHZ_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              cfg_we,
  input  logic              cfg_fast,
  input  logic              cfg_duty16,
  input  logic [CCR_W-1:0]  cfg_ccr,
  input  logic [RISE_W-1:0] cfg_rise,
  input  logic [MHZ_W-1:0]  cfg_mhz,
  output logic              fast_q,
  output logic              duty16_q,
  output logic [CCR_W-1:0]  ccr_q,
  output logic [RISE_W-1:0] rise_q,
  output logic [MHZ_W-1:0]  mhz_q
);
  // Writes land only while the generator is stopped (R9).
  always_ff @(posedge clk) begin
    if (rst) begin
      fast_q   <= 1'b0;
      duty16_q <= 1'b0;
      ccr_q    <= '0;
      rise_q   <= '0;
      mhz_q    <= '0;
    end else if (cfg_we && !enable) begin
      fast_q   <= cfg_fast;
      duty16_q <= cfg_duty16;
      ccr_q    <= cfg_ccr;
      rise_q   <= cfg_rise;
      mhz_q    <= cfg_mhz;
    end
  end
endmodule

// File: rtl/scl_phase_len.sv
module scl_phase_len #(
  parameter int CCR_W = 12,
  parameter int LEN_W = CCR_W + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fast,
  input  logic             duty16,
  input  logic [CCR_W-1:0] ccr,
  output logic [LEN_W-1:0] low_len,
  output logic [LEN_W-1:0] high_len
);
  localparam int STD_MIN  = 4;
  localparam int FAST_MIN = 1;

  logic [CCR_W-1:0] c_std, c_fast, c_sel;
  logic [LEN_W-1:0] ce, low_n, high_n;

  always_comb begin
    c_std  = (ccr < CCR_W'(STD_MIN)) ? CCR_W'(STD_MIN) : ccr;     // R3
    c_fast = (ccr < CCR_W'(FAST_MIN)) ? CCR_W'(FAST_MIN) : ccr;   // R6
    c_sel  = fast ? c_fast : c_std;
    ce     = LEN_W'(c_sel);
    if (!fast) begin            // R2: 1:1
      low_n  = ce;
      high_n = ce;
    end else if (!duty16) begin // R4: 2:1
      low_n  = ce << 1;
      high_n = ce;
    end else begin              // R5: 16:9
      low_n  = ce << 4;
      high_n = (ce << 3) + ce;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_len  <= LEN_W'(STD_MIN);
      high_len <= LEN_W'(STD_MIN);
    end else begin
      low_len  <= low_n;
      high_len <= high_n;
    end
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_timing_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int RISE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              scl_in,
  input  logic [LEN_W-1:0]  low_len,
  input  logic [LEN_W-1:0]  high_len,
  input  logic [RISE_W-1:0] rise,
  output logic              scl_oe,
  output logic              low_end,
  output logic              high_end,
  output scl_phase_e        phase
);
  localparam logic [LEN_W-1:0] CNT_MAX = '1;

  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] rise_ext;
  logic             rise_done;

  assign rise_ext  = LEN_W'(rise);
  assign rise_done = (cnt >= rise_ext) && scl_in;   // R7

  always_ff @(posedge clk) begin
    if (rst || !run) begin      // R1, R10, R11
      phase    <= PH_IDLE;
      cnt      <= '0;
      scl_oe   <= 1'b0;
      low_end  <= 1'b0;
      high_end <= 1'b0;
    end else begin
      low_end  <= 1'b0;
      high_end <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          phase  <= PH_LOW;
          cnt    <= LEN_W'(1);
          scl_oe <= 1'b1;
        end
        PH_LOW: begin
          if (cnt >= low_len) begin
            phase   <= PH_RISE;
            cnt     <= LEN_W'(1);
            scl_oe  <= 1'b0;
            low_end <= 1'b1;    // R8
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_RISE: begin
          if (rise_done) begin
            phase <= PH_HIGH;
            cnt   <= LEN_W'(1);
          end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt >= high_len) begin
            phase    <= PH_LOW;
            cnt      <= LEN_W'(1);
            scl_oe   <= 1'b1;
            high_end <= 1'b1;   // R8
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int CCR_W  = 12,
  parameter int RISE_W = 6,
  parameter int MHZ_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              cfg_we,
  input  logic              cfg_fast,
  input  logic              cfg_duty16,
  input  logic [CCR_W-1:0]  cfg_ccr,
  input  logic [RISE_W-1:0] cfg_rise,
  input  logic [MHZ_W-1:0]  cfg_mhz,
  input  logic              scl_in,
  output logic              scl_oe,
  output logic              low_end,
  output logic              high_end
);
  localparam int LEN_W = CCR_W + 4;

  logic              fast_q, duty16_q;
  logic [CCR_W-1:0]  ccr_q;
  logic [RISE_W-1:0] rise_q;
  logic [MHZ_W-1:0]  mhz_q;
  logic [LEN_W-1:0]  low_len, high_len;
  logic              run;
  scl_phase_e        phase;

  scl_cfg_regs #(.CCR_W(CCR_W), .RISE_W(RISE_W), .MHZ_W(MHZ_W)) u_cfg (
    .clk(clk), .rst(rst), .enable(enable), .cfg_we(cfg_we),
    .cfg_fast(cfg_fast), .cfg_duty16(cfg_duty16), .cfg_ccr(cfg_ccr),
    .cfg_rise(cfg_rise), .cfg_mhz(cfg_mhz),
    .fast_q(fast_q), .duty16_q(duty16_q), .ccr_q(ccr_q),
    .rise_q(rise_q), .mhz_q(mhz_q)
  );

  scl_phase_len #(.CCR_W(CCR_W), .LEN_W(LEN_W)) u_len (
    .clk(clk), .rst(rst), .fast(fast_q), .duty16(duty16_q), .ccr(ccr_q),
    .low_len(low_len), .high_len(high_len)
  );

  assign run = enable && (mhz_q != '0);   // R11

  scl_phase_fsm #(.LEN_W(LEN_W), .RISE_W(RISE_W)) u_fsm (
    .clk(clk), .rst(rst), .run(run), .scl_in(scl_in),
    .low_len(low_len), .high_len(high_len), .rise(rise_q),
    .scl_oe(scl_oe), .low_end(low_end), .high_end(high_end), .phase(phase)
  );
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk
  import scl_timing_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             run,
  input logic             scl_in,
  input logic             scl_oe,
  input logic             low_end,
  input logic             high_end,
  input scl_phase_e       phase,
  input logic [LEN_W-1:0] low_len,
  input logic [LEN_W-1:0] high_len
);
  // R10
  a_r10_disable_releases: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !scl_oe);
  // R11
  a_r11_no_start_without_run: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!scl_oe && !low_end && !high_end));
  // R8
  a_r8_low_end_at_release: assert property (@(posedge clk) disable iff (rst)
    low_end |-> (!scl_oe && $past(scl_oe)));
  a_r8_high_end_at_pull: assert property (@(posedge clk) disable iff (rst)
    high_end |-> (scl_oe && !$past(scl_oe)));
  a_r8_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(low_end && high_end));
  // R7
  a_r7_stretch_holds: assert property (@(posedge clk) disable iff (rst)
    (run && phase == PH_RISE && !scl_in) |=> (!scl_oe && !high_end));
  // R9
  a_r9_lengths_locked: assert property (@(posedge clk) disable iff (rst)
    (enable && $past(enable)) |-> ($stable(low_len) && $stable(high_len)));
  // R3, R6
  a_r6_lengths_nonzero: assert property (@(posedge clk) disable iff (rst)
    (low_len != '0) && (high_len != '0));
endmodule

bind scl_timing_gen scl_timing_gen_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .run(run), .scl_in(scl_in),
  .scl_oe(scl_oe), .low_end(low_end), .high_end(high_end), .phase(phase),
  .low_len(low_len), .high_len(high_len)
);

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;
  localparam int CCR_W  = 12;
  localparam int RISE_W = 6;
  localparam int MHZ_W  = 6;
  localparam int NV     = 7;
  // fast, duty16, ccr, rise, expected low, expected released (rise wait + high)
  localparam int VEC [NV][6] = '{
    '{0, 0, 10, 3, 10, 13},   // R2
    '{0, 0,  2, 0,  4,  5},   // R3 clamp to 4
    '{1, 0,  5, 2, 10,  7},   // R4
    '{1, 1,  2, 4, 32, 22},   // R5
    '{1, 0,  0, 0,  2,  2},   // R6 clamp to 1, 2:1
    '{1, 1,  0, 0, 16, 10},   // R6 clamp to 1, 16:9
    '{0, 0,  4, 7,  4, 11}    // R7 rise wait
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic cfg_we = 1'b0;
  logic cfg_fast = 1'b0;
  logic cfg_duty16 = 1'b0;
  logic [CCR_W-1:0]  cfg_ccr = '0;
  logic [RISE_W-1:0] cfg_rise = '0;
  logic [MHZ_W-1:0]  cfg_mhz = '0;
  logic stretch = 1'b0;
  logic scl_in;
  logic scl_oe, low_end, high_end;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign scl_in = !scl_oe && !stretch;

  scl_timing_gen #(.CCR_W(CCR_W), .RISE_W(RISE_W), .MHZ_W(MHZ_W)) uut (
    .clk(clk), .rst(rst), .enable(enable), .cfg_we(cfg_we),
    .cfg_fast(cfg_fast), .cfg_duty16(cfg_duty16), .cfg_ccr(cfg_ccr),
    .cfg_rise(cfg_rise), .cfg_mhz(cfg_mhz), .scl_in(scl_in),
    .scl_oe(scl_oe), .low_end(low_end), .high_end(high_end)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int f, input int d, input int c, input int r, input int m);
    @(negedge clk);
    cfg_fast = f[0]; cfg_duty16 = d[0];
    cfg_ccr = CCR_W'(c); cfg_rise = RISE_W'(r); cfg_mhz = MHZ_W'(m);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  // Measures one full low run and the following released run of scl_oe.
  task automatic measure(output int lo, output int hi, output bit le_ok, output bit he_ok);
    int g;
    lo = 0; hi = 0; g = 0; le_ok = 1'b0; he_ok = 1'b0;
    while (scl_oe && g < 4000) begin @(negedge clk); g++; end
    while (!scl_oe && g < 4000) begin @(negedge clk); g++; end
    while (scl_oe && g < 4000) begin lo++; @(negedge clk); g++; end
    le_ok = low_end;
    while (!scl_oe && g < 4000) begin
      hi++; @(negedge clk); g++;
      if (!scl_oe) le_ok = le_ok && !low_end;
    end
    he_ok = high_end;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lo, hi, cnt;
    bit le_ok, he_ok, seen;
    repeat (3) @(negedge clk);
    chk(!scl_oe && !low_end && !high_end, "R1 in reset", scl_oe, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!scl_oe && !low_end && !high_end, "R1 after reset", scl_oe, 0);

    // R11: MHz still 0, generator must not start
    enable = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); seen = seen || scl_oe; end
    chk(!seen, "R11 stays released with MHz=0", seen, 0);
    enable = 1'b0;

    for (int v = 0; v < NV; v++) begin
      write_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 16);
      enable = 1'b1;
      measure(lo, hi, le_ok, he_ok);
      chk(lo == VEC[v][4], $sformatf("R2/R3/R4/R5/R6 low vec%0d", v), lo, VEC[v][4]);
      chk(hi == VEC[v][5], $sformatf("R7 released vec%0d", v), hi, VEC[v][5]);
      chk(le_ok && he_ok, $sformatf("R8 pulses vec%0d", v), {le_ok, he_ok}, 3);
      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      chk(!scl_oe, $sformatf("R10 release vec%0d", v), scl_oe, 0);
    end

    // R9: write while enabled is discarded
    write_cfg(0, 0, 10, 3, 16);
    enable = 1'b1;
    @(negedge clk);
    chk(scl_oe, "R10 low phase starts next cycle", scl_oe, 1);
    cfg_ccr = CCR_W'(30); cfg_rise = RISE_W'(0); cfg_fast = 1'b1; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    measure(lo, hi, le_ok, he_ok);
    chk(lo == 10 && hi == 13, "R9 locked while enabled", lo, 10);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    measure(lo, hi, le_ok, he_ok);
    chk(lo == 10 && hi == 13, "R9 discarded write not applied later", lo, 10);
    enable = 1'b0;
    @(negedge clk);

    // R7: clock stretching holds the released state
    write_cfg(0, 0, 4, 0, 16);
    stretch = 1'b1;
    enable = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i >= 8) seen = seen || scl_oe || high_end;
    end
    chk(!seen, "R7 stretch holds high phase", seen, 0);
    stretch = 1'b0;
    cnt = 0;
    while (!scl_oe && cnt < 100) begin @(negedge clk); cnt++; end
    chk(cnt == 5, "R7 high phase after stretch release", cnt, 5);
    chk(high_end, "R8 high_end after stretch", high_end, 1);
    enable = 1'b0;
    @(negedge clk);
    chk(!scl_oe, "R10 release after stretch test", scl_oe, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule